// File: doc/BRIEF.md
# CDS Acquisition Timing Sequencer

This block runs one windowed readout cycle for a group of charge-integrating channels. A single start request launches a fixed sequence: integrator reset, a guard interval for the reset tail to die away, a baseline sample, an integration window, a signal sample, and finally a hold interval in which the converter is told to start. Every duration comes from a configuration word that the block copies when it accepts a start. Both sample apertures therefore sit at the same offset from the reset edge on every cycle, and so on every channel.

The block also issues a one-clock strobe that tells the channel multiplexer to move to its next input. The strobe is placed a programmable settle interval ahead of the baseline sample, so the mux never switches inside the protected sampling region. The sequencer checks each configuration before it accepts it. If a setting could not be honoured, it raises an error flag and does not start. Clearing a mode input removes the baseline sample while leaving all other timing untouched, so two-sample and single-sample readings can be compared under identical timing.

Top module: `cds_seq_top`

## Requirements
- R1: Each cycle follows the fixed order reset, guard, first sample, integrate, second sample, hold with convert, done. No phase is skipped or reordered.
- R2: A start sampled high on an idle clock edge drives `reset_o` high from the next clock for exactly `cfg_rst_len_i` cycles. It is followed by `cfg_guard_len_i` guard cycles with every strobe low, and `smp1_o` fires on the clock after the guard.
- R3: `intg_o` is high for exactly `cfg_tint_len_i` cycles, starting the clock after the first sample slot. `smp2_o` fires on the clock after the integration window. Both sample strobes are one clock wide.
- R4: `hold_o` is high for `cfg_conv_slot_i + 1` cycles, starting the clock after `smp2_o`. `conv_o` is high only on the last hold cycle, so a conversion never begins in the same cycle as a sample or before hold has been high for a full clock.
- R5: `mux_upd_o` pulses for one clock exactly `cfg_settle_len_i` cycles before the first sample slot. This places it within the reset or guard interval, never while a sample, integrate or hold strobe is high.
- R6: With `cfg_cds_en_i` low, `smp1_o` stays low. Every other strobe keeps the timing it would have with the mode enabled.
- R7: The configuration is copied only when a start is accepted. A configuration change during a cycle has no effect until the next cycle.
- R8: A start is refused, `cfg_err_o` goes high and no reset is driven if any length is zero or if the settle length exceeds reset length plus guard length. `cfg_err_o` stays high until a valid start is accepted.
- R9: `done_o` pulses for one clock on the clock after `conv_o`.
- R10: A start that arrives during a cycle is remembered. The next cycle begins its reset on the clock after `done_o`.
- R11: While `rst_n` is low, and right after it is released, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Cycle start request |
| cfg_rst_len_i | input | CNT_W | Reset level length in clocks |
| cfg_guard_len_i | input | CNT_W | Guard clocks between reset release and first sample |
| cfg_tint_len_i | input | CNT_W | Integration window length in clocks |
| cfg_settle_len_i | input | CNT_W | Clocks from mux update to first sample slot |
| cfg_conv_slot_i | input | CNT_W | Hold clocks before the convert strobe |
| cfg_cds_en_i | input | 1 | 1: two-sample mode, 0: single-sample mode |
| reset_o | output | 1 | Integrator reset level |
| intg_o | output | 1 | Integration gate level |
| smp1_o | output | 1 | Baseline sample strobe |
| smp2_o | output | 1 | Signal sample strobe |
| hold_o | output | 1 | Hold level |
| conv_o | output | 1 | Converter start strobe |
| mux_upd_o | output | 1 | Channel mux update strobe |
| done_o | output | 1 | Cycle-done pulse |
| cfg_err_o | output | 1 | Refused-configuration flag |

## Verification
The hardest situations to reach are the ones where a start request or a configuration write arrives in the middle of a running cycle. A simple start-then-wait bench never produces them. The stimulus therefore pokes inputs at a chosen cycle offset inside an ongoing sequence: a second start partway through, or a different configuration written shortly after the reset begins. It then compares every output bit, cycle by cycle, against a timeline computed from the lengths that should have been latched. The settle boundary, where the mux strobe lands on the very first reset clock, is reached by sweeping the settle length up to reset plus guard.

// File: rtl/cds_seq_pkg.sv
package cds_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RST,
        PH_GUARD,
        PH_SMP1,
        PH_INTG,
        PH_SMP2,
        PH_HOLD,
        PH_DONE
    } phase_e;

endpackage

// File: rtl/cds_cfg_check.sv
module cds_cfg_check #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] rst_len_i,
    input  logic [CNT_W-1:0] guard_len_i,
    input  logic [CNT_W-1:0] tint_len_i,
    input  logic [CNT_W-1:0] settle_len_i,
    input  logic [CNT_W-1:0] conv_slot_i,
    output logic             cfg_ok_o,
    output logic [CNT_W:0]   mux_at_o
);
    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] pre_len;
    logic [EXT_W-1:0] settle_ext;
    logic             any_zero;

    always_comb begin
        pre_len    = EXT_W'(rst_len_i) + EXT_W'(guard_len_i);
        settle_ext = EXT_W'(settle_len_i);
        any_zero   = (rst_len_i == '0) || (guard_len_i == '0) || (tint_len_i == '0)
                  || (settle_len_i == '0) || (conv_slot_i == '0);
        // mux strobe must land inside reset+guard, at least one clock before sample 1
        cfg_ok_o   = !any_zero && (settle_ext <= pre_len);
        mux_at_o   = pre_len - settle_ext;
    end

endmodule

// File: rtl/cds_seq_core.sv
module cds_seq_core
    import cds_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cfg_ok_i,
    input  logic [CNT_W:0]   mux_at_i,
    input  logic [CNT_W-1:0] rst_len_i,
    input  logic [CNT_W-1:0] guard_len_i,
    input  logic [CNT_W-1:0] tint_len_i,
    input  logic [CNT_W-1:0] conv_slot_i,
    input  logic             cds_en_i,
    output logic             reset_o,
    output logic             intg_o,
    output logic             smp1_o,
    output logic             smp2_o,
    output logic             hold_o,
    output logic             conv_o,
    output logic             mux_upd_o,
    output logic             done_o,
    output logic             cfg_err_o
);
    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W:0]   el;
        logic [CNT_W:0]   mux_at;
        logic [CNT_W-1:0] guard;
        logic [CNT_W-1:0] tint;
        logic [CNT_W-1:0] conv;
        logic             cds;
        logic             pend;
        logic             err;
    } seq_t;

    seq_t s_d, s_q;
    logic go;

    always_comb begin
        s_d = s_q;
        go  = start_i | s_q.pend;
        if (s_q.phase == PH_IDLE || s_q.phase == PH_DONE) begin
            s_d.pend  = 1'b0;
            s_d.phase = PH_IDLE;
            if (go) begin
                if (cfg_ok_i) begin
                    s_d.phase  = PH_RST;
                    s_d.cnt    = rst_len_i - 1'b1;
                    s_d.el     = '0;
                    s_d.mux_at = mux_at_i;
                    s_d.guard  = guard_len_i;
                    s_d.tint   = tint_len_i;
                    s_d.conv   = conv_slot_i;
                    s_d.cds    = cds_en_i;
                    s_d.err    = 1'b0;
                end else begin
                    s_d.err = 1'b1;
                end
            end
        end else begin
            s_d.pend = s_q.pend | start_i;
            s_d.cnt  = s_q.cnt - 1'b1;
            unique case (s_q.phase)
                PH_RST: begin
                    s_d.el = s_q.el + 1'b1;
                    if (s_q.cnt == '0) begin
                        s_d.phase = PH_GUARD;
                        s_d.cnt   = s_q.guard - 1'b1;
                    end
                end
                PH_GUARD: begin
                    s_d.el = s_q.el + 1'b1;
                    if (s_q.cnt == '0) s_d.phase = PH_SMP1;
                end
                PH_SMP1: begin
                    s_d.phase = PH_INTG;
                    s_d.cnt   = s_q.tint - 1'b1;
                end
                PH_INTG: begin
                    if (s_q.cnt == '0) s_d.phase = PH_SMP2;
                end
                PH_SMP2: begin
                    s_d.phase = PH_HOLD;
                    s_d.cnt   = s_q.conv;
                end
                PH_HOLD: begin
                    if (s_q.cnt == '0) s_d.phase = PH_DONE;
                end
                default: s_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        reset_o   = (s_q.phase == PH_RST);
        smp1_o    = (s_q.phase == PH_SMP1) && s_q.cds;
        intg_o    = (s_q.phase == PH_INTG);
        smp2_o    = (s_q.phase == PH_SMP2);
        hold_o    = (s_q.phase == PH_HOLD);
        conv_o    = (s_q.phase == PH_HOLD) && (s_q.cnt == '0);
        done_o    = (s_q.phase == PH_DONE);
        mux_upd_o = ((s_q.phase == PH_RST) || (s_q.phase == PH_GUARD)) && (s_q.el == s_q.mux_at);
        cfg_err_o = s_q.err;
    end

endmodule

// File: rtl/cds_seq_top.sv
module cds_seq_top #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] cfg_rst_len_i,
    input  logic [CNT_W-1:0] cfg_guard_len_i,
    input  logic [CNT_W-1:0] cfg_tint_len_i,
    input  logic [CNT_W-1:0] cfg_settle_len_i,
    input  logic [CNT_W-1:0] cfg_conv_slot_i,
    input  logic             cfg_cds_en_i,
    output logic             reset_o,
    output logic             intg_o,
    output logic             smp1_o,
    output logic             smp2_o,
    output logic             hold_o,
    output logic             conv_o,
    output logic             mux_upd_o,
    output logic             done_o,
    output logic             cfg_err_o
);
    logic           cfg_ok;
    logic [CNT_W:0] mux_at;

    cds_cfg_check #(.CNT_W(CNT_W)) u_check (
        .rst_len_i    (cfg_rst_len_i),
        .guard_len_i  (cfg_guard_len_i),
        .tint_len_i   (cfg_tint_len_i),
        .settle_len_i (cfg_settle_len_i),
        .conv_slot_i  (cfg_conv_slot_i),
        .cfg_ok_o     (cfg_ok),
        .mux_at_o     (mux_at)
    );

    cds_seq_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cfg_ok_i    (cfg_ok),
        .mux_at_i    (mux_at),
        .rst_len_i   (cfg_rst_len_i),
        .guard_len_i (cfg_guard_len_i),
        .tint_len_i  (cfg_tint_len_i),
        .conv_slot_i (cfg_conv_slot_i),
        .cds_en_i    (cfg_cds_en_i),
        .reset_o     (reset_o),
        .intg_o      (intg_o),
        .smp1_o      (smp1_o),
        .smp2_o      (smp2_o),
        .hold_o      (hold_o),
        .conv_o      (conv_o),
        .mux_upd_o   (mux_upd_o),
        .done_o      (done_o),
        .cfg_err_o   (cfg_err_o)
    );

endmodule

// File: rtl/cds_seq_chk.sv
module cds_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic reset_o,
    input logic intg_o,
    input logic smp1_o,
    input logic smp2_o,
    input logic hold_o,
    input logic conv_o,
    input logic mux_upd_o,
    input logic done_o,
    input logic cfg_err_o
);
    a_r1_smp2_after_intg: assert property (@(posedge clk) disable iff (!rst_n)
        smp2_o |-> $past(intg_o));
    a_r1_hold_after_smp2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> $past(smp2_o));
    a_r2_guard_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reset_o) |-> (!smp1_o && !intg_o));
    a_r3_smp1_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        smp1_o |=> !smp1_o);
    a_r3_smp2_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        smp2_o |=> !smp2_o);
    a_r4_conv_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        conv_o |-> (hold_o && $past(hold_o)));
    a_r5_mux_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
        mux_upd_o |-> !(smp1_o || smp2_o || intg_o || hold_o || conv_o));
    a_r8_err_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err_o) |-> !reset_o);
    a_r9_done_after_conv: assert property (@(posedge clk) disable iff (!rst_n)
        conv_o |=> done_o);
    a_r9_done_needs_conv: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(conv_o));
endmodule

bind cds_seq_top cds_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reset_o   (reset_o),
    .intg_o    (intg_o),
    .smp1_o    (smp1_o),
    .smp2_o    (smp2_o),
    .hold_o    (hold_o),
    .conv_o    (conv_o),
    .mux_upd_o (mux_upd_o),
    .done_o    (done_o),
    .cfg_err_o (cfg_err_o)
);

// File: tb/cds_seq_top_test.sv
module cds_seq_top_test;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] c_rst = 8'd1, c_grd = 8'd1, c_tint = 8'd1, c_set = 8'd1, c_conv = 8'd1;
    logic             c_cds = 1'b1;
    logic reset_o, intg_o, smp1_o, smp2_o, hold_o, conv_o, mux_upd_o, done_o, cfg_err_o;

    int compared = 0;
    int mismatched = 0;

    always #2.5 clk = ~clk;

    cds_seq_top #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .cfg_rst_len_i(c_rst), .cfg_guard_len_i(c_grd), .cfg_tint_len_i(c_tint),
        .cfg_settle_len_i(c_set), .cfg_conv_slot_i(c_conv), .cfg_cds_en_i(c_cds),
        .reset_o(reset_o), .intg_o(intg_o), .smp1_o(smp1_o), .smp2_o(smp2_o),
        .hold_o(hold_o), .conv_o(conv_o), .mux_upd_o(mux_upd_o), .done_o(done_o),
        .cfg_err_o(cfg_err_o)
    );

    // bit order: mux, reset, smp1, intg, smp2, hold, conv, done
    function automatic logic [7:0] act_vec();
        return {mux_upd_o, reset_o, smp1_o, intg_o, smp2_o, hold_o, conv_o, done_o};
    endfunction

    function automatic logic [7:0] exp_vec(int t, int r, int g, int i, int s, int c, bit cds);
        int p1 = r + g;
        int p2 = p1 + i + 1;
        logic [7:0] v;
        v[7] = (t == p1 - s);
        v[6] = (t < r);
        v[5] = cds && (t == p1);
        v[4] = (t > p1) && (t <= p1 + i);
        v[3] = (t == p2);
        v[2] = (t > p2) && (t <= p2 + 1 + c);
        v[1] = (t == p2 + 1 + c);
        v[0] = (t == p2 + 2 + c);
        return v;
    endfunction

    function automatic string tag_of(logic [7:0] d);
        if (d[7]) return "R5";
        if (d[6]) return "R2";
        if (d[5]) return "R6";
        if (d[4] || d[3]) return "R3";
        if (d[2] || d[1]) return "R4";
        if (d[0]) return "R9";
        return "R1";
    endfunction

    task automatic check_vec(logic [7:0] exp, string ctx);
        logic [7:0] a = act_vec();
        compared++;
        if (a !== exp) begin
            mismatched++;
            $display("FAIL %s %s: outputs %b expected %b", tag_of(a ^ exp), ctx, a, exp);
        end
    endtask

    task automatic check_bit(logic a, logic e, string ctx);
        compared++;
        if (a !== e) begin
            mismatched++;
            $display("FAIL %s: got %b expected %b", ctx, a, e);
        end
    endtask

    task automatic set_cfg(int r, int g, int i, int s, int c, bit cds);
        c_rst = CNT_W'(r); c_grd = CNT_W'(g); c_tint = CNT_W'(i);
        c_set = CNT_W'(s); c_conv = CNT_W'(c); c_cds = cds;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Compares a full cycle starting at current negedge (t=0). poke: 0 none,
    // 1 start pulse at t=pt, 2 config rewrite at t=pt.
    task automatic watch(int r, int g, int i, int s, int c, bit cds, int poke, int pt, string ctx);
        int tend = r + g + i + c + 3;
        for (int t = 0; t <= tend; t++) begin
            check_vec(exp_vec(t, r, g, i, s, c, cds), ctx);
            if (poke == 1 && t == pt) start = 1'b1;
            else start = 1'b0;
            if (poke == 2 && t == pt) set_cfg(2, 1, 1, 1, 1, 1'b1);
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        check_vec(8'h00, "R11 in reset");
        check_bit(cfg_err_o, 1'b0, "R11 err in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_vec(8'h00, "R11 after reset");

        // R1 R2 R3 R4 R5 R6 R9: sweep; whole-vector compare also enforces R1 order
        for (int r = 1; r <= 3; r++)
            for (int g = 1; g <= 3; g++)
                for (int s = 1; s <= r + g; s++)
                    for (int i = 1; i <= 3; i++)
                        for (int c = 1; c <= 2; c++)
                            for (int cd = 0; cd <= 1; cd++) begin
                                set_cfg(r, g, i, s, c, cd[0]);
                                pulse_start();
                                watch(r, g, i, s, c, cd[0], 0, 0, "R1 sweep");
                                check_vec(8'h00, "R1 idle after done");
                            end

        // R7: config rewritten mid-cycle keeps the latched values
        set_cfg(3, 2, 3, 4, 2, 1'b0);
        pulse_start();
        watch(3, 2, 3, 4, 2, 1'b0, 2, 1, "R7 mid-cycle change");
        check_vec(8'h00, "R7 idle");
        pulse_start();
        watch(2, 1, 1, 1, 1, 1'b1, 0, 0, "R7 next cycle uses new cfg");
        check_vec(8'h00, "R7 idle 2");

        // R10: start during a cycle is held until done
        set_cfg(2, 2, 2, 3, 1, 1'b1);
        pulse_start();
        watch(2, 2, 2, 3, 1, 1'b1, 1, 3, "R10 first cycle");
        watch(2, 2, 2, 3, 1, 1'b1, 0, 0, "R10 held start cycle");
        check_vec(8'h00, "R10 idle");

        // R8: refused configurations
        for (int k = 0; k < 7; k++) begin
            case (k)
                0: set_cfg(0, 2, 2, 1, 1, 1'b1);
                1: set_cfg(2, 0, 2, 1, 1, 1'b1);
                2: set_cfg(2, 2, 0, 1, 1, 1'b1);
                3: set_cfg(2, 2, 2, 0, 1, 1'b1);
                4: set_cfg(2, 2, 2, 1, 0, 1'b1);
                5: set_cfg(2, 2, 2, 5, 1, 1'b1);
                default: set_cfg(1, 1, 1, 3, 1, 1'b1);
            endcase
            pulse_start();
            check_bit(cfg_err_o, 1'b1, "R8 err raised");
            check_vec(8'h00, "R8 no cycle");
            @(negedge clk);
            check_vec(8'h00, "R8 still idle");
            check_bit(cfg_err_o, 1'b1, "R8 err sticky");
        end
        set_cfg(2, 2, 1, 4, 1, 1'b1);
        pulse_start();
        check_bit(cfg_err_o, 1'b0, "R8 err cleared by valid start");
        watch(2, 2, 1, 4, 1, 1'b1, 0, 0, "R8 valid after error");
        check_vec(8'h00, "R8 idle");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule